// File: doc/BRIEF.md
# Paged Program Counter with Writable Low Byte

This block holds the instruction fetch address of a small word-addressed controller whose data path is 8 bits wide and whose instruction address is 11 bits wide. Consecutive instruction words differ by one, and with nothing else requested the counter advances by one each time an instruction retires. It wraps from the top of the address space back to zero.

Software can treat the bottom byte of the counter as an ordinary data register. It can write a value into it, or add an 8-bit operand to it, and either action is a jump. The upper three address bits do not come from the data path. They are taken from a separate page register that software writes beforehand, and they are loaded into the counter only when the low byte is written.

The operand that an add sees is the address of the next word. An offset of zero therefore falls through to the following instruction, which is how a computed jump into a table of jump instructions is indexed. The add wraps within the byte and never carries into the upper bits, so software must adjust the page register itself before a table crosses a 256-word boundary.

A jump instruction with an immediate target loads all 11 bits at once and leaves the page register alone. All controls are sampled only in a cycle where `step` marks an instruction as retiring. Every pin is a plain control or value pin. There is no handshake, and the block never applies back-pressure.

Top module: `split_latch_pc`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `fetch_addr` to 0 and the page register to 0. Afterwards `latch_rd` reads 0 and `pcl_rd` reads 1.
- R2: On a retiring cycle with no jump, no low-byte write and no low-byte add, `fetch_addr` becomes `fetch_addr + 1` modulo 2048. So 0x7FF is followed by 0x000.
- R3: On a cycle with `step` low, `fetch_addr` and the page register keep their values, whatever the other controls carry.
- R4: On a retiring cycle with `goto_en` high, `fetch_addr` becomes `goto_target`, and the page register is unchanged unless `lat_wr_en` is also high.
- R5: On a retiring cycle with `lat_wr_en` high, the page register takes `lat_data[2:0]` and bits 7:3 of `lat_data` are discarded. This alone changes the fetch address only by the normal increment.
- R6: On a retiring cycle with `pcl_wr_en` high and `goto_en` low, `fetch_addr` becomes {page register, `pcl_data`}, with the page register in bits 10:8. The page value used is the one held before that edge, even when `lat_wr_en` writes a new one in the same cycle.
- R7: On a retiring cycle with `pcl_add_en` high and both `goto_en` and `pcl_wr_en` low, `fetch_addr` becomes {page register, (low byte of `fetch_addr + 1`) + `pcl_data` modulo 256}. No carry enters bits 10:8.
- R8: `pcl_rd` always shows bits 7:0 of `fetch_addr + 1`. `latch_rd` shows the page register in bits 2:0, and bits 7:3 read as 0.
- R9: When several next-address sources are requested together, `goto_en` wins over `pcl_wr_en`, `pcl_wr_en` wins over `pcl_add_en`, and any of them wins over the plain increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | An instruction retires this cycle; all other controls are qualified by it |
| goto_en | input | 1 | Load the whole address from `goto_target` |
| goto_target | input | 11 | Immediate jump target |
| pcl_wr_en | input | 1 | Write `pcl_data` into the low byte and load the upper bits from the page register |
| pcl_add_en | input | 1 | Add `pcl_data` to the next-word low byte and load the upper bits from the page register |
| pcl_data | input | 8 | Low-byte write value or add operand |
| lat_wr_en | input | 1 | Write the page register |
| lat_data | input | 8 | Page register write value (bits 2:0 kept) |
| fetch_addr | output | 11 | Address of the instruction word being executed |
| pcl_rd | output | 8 | Read value of the low-byte register (next-word low byte) |
| latch_rd | output | 8 | Read value of the page register, zero-extended |

## Verification
The case most likely to break is a page-register write in the same retiring cycle as a low-byte write. The jump must use the page value that was held before the edge, while the page register takes the new value for later jumps. The bench provokes this by raising `lat_wr_en` and `pcl_wr_en` together. It then checks that `fetch_addr` carries the old page in bits 10:8 and that `latch_rd` already shows the new one. A second overlap gives a jump and a low-byte write together, and then a write and an add together. Both are judged by which target appears on `fetch_addr` one edge later.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Selected source of the next fetch address
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INC  = 2'd1,
    SRC_JUMP = 2'd2,
    SRC_PAGE = 2'd3
  } nxt_src_e;
endpackage

// File: rtl/pcs_sel.sv
module pcs_sel
  import pcs_pkg::*;
(
  input  logic     step,
  input  logic     goto_en,
  input  logic     pcl_wr_en,
  input  logic     pcl_add_en,
  output nxt_src_e src,
  output logic     use_add
);
  // Priority: immediate jump, then low-byte write, then low-byte add, then increment
  always_comb begin
    src     = SRC_HOLD;
    use_add = 1'b0;
    if (step) begin
      if (goto_en) begin
        src = SRC_JUMP;
      end else if (pcl_wr_en) begin
        src = SRC_PAGE;
      end else if (pcl_add_en) begin
        src     = SRC_PAGE;
        use_add = 1'b1;
      end else begin
        src = SRC_INC;
      end
    end
  end
endmodule

// File: rtl/pcs_page_latch.sv
module pcs_page_latch #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [HI_W-1:0]   page
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page <= '0;
    end else if (wr_en) begin
      page <= wr_data[HI_W-1:0];
    end
  end
endmodule

// File: rtl/pcs_next.sv
module pcs_next
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic [ADDR_W-1:0] pc,
  input  nxt_src_e          src,
  input  logic              use_add,
  input  logic [ADDR_W-1:0] goto_target,
  input  logic [DATA_W-1:0] pcl_data,
  input  logic [HI_W-1:0]   page,
  output logic [ADDR_W-1:0] pc_nxt,
  output logic [DATA_W-1:0] seq_low
);
  logic [ADDR_W-1:0] pc_inc;
  logic [DATA_W-1:0] low_sum;
  logic [DATA_W-1:0] page_low;

  assign pc_inc   = pc + ADDR_W'(1);
  assign seq_low  = pc_inc[DATA_W-1:0];
  // Byte-wide add: the carry out is dropped on purpose
  assign low_sum  = seq_low + pcl_data;
  assign page_low = use_add ? low_sum : pcl_data;

  always_comb begin
    unique case (src)
      SRC_INC:  pc_nxt = pc_inc;
      SRC_JUMP: pc_nxt = goto_target;
      SRC_PAGE: pc_nxt = {page, page_low};
      default:  pc_nxt = pc;
    endcase
  end
endmodule

// File: rtl/split_latch_pc.sv
module split_latch_pc
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              goto_en,
  input  logic [ADDR_W-1:0] goto_target,
  input  logic              pcl_wr_en,
  input  logic              pcl_add_en,
  input  logic [DATA_W-1:0] pcl_data,
  input  logic              lat_wr_en,
  input  logic [DATA_W-1:0] lat_data,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] pcl_rd,
  output logic [DATA_W-1:0] latch_rd
);
  nxt_src_e          src;
  logic              use_add;
  logic [HI_W-1:0]   page;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_nxt;
  logic [DATA_W-1:0] seq_low;

  pcs_sel u_sel (
    .step       (step),
    .goto_en    (goto_en),
    .pcl_wr_en  (pcl_wr_en),
    .pcl_add_en (pcl_add_en),
    .src        (src),
    .use_add    (use_add)
  );

  pcs_page_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (step & lat_wr_en),
    .wr_data (lat_data),
    .page    (page)
  );

  pcs_next #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_next (
    .pc          (pc_q),
    .src         (src),
    .use_add     (use_add),
    .goto_target (goto_target),
    .pcl_data    (pcl_data),
    .page        (page),
    .pc_nxt      (pc_nxt),
    .seq_low     (seq_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_nxt;
    end
  end

  assign fetch_addr = pc_q;
  assign pcl_rd     = seq_low;
  assign latch_rd   = {{(DATA_W-HI_W){1'b0}}, page};
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic              goto_en,
  input logic [ADDR_W-1:0] goto_target,
  input logic              pcl_wr_en,
  input logic              pcl_add_en,
  input logic [DATA_W-1:0] pcl_data,
  input logic              lat_wr_en,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [DATA_W-1:0] latch_rd
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (fetch_addr == '0) && (latch_rd == '0));

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(fetch_addr) && $stable(latch_rd));

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (step && !goto_en && !pcl_wr_en && !pcl_add_en)
      |=> fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(1)));

  a_r4_goto_target: assert property (@(posedge clk) disable iff (rst)
    (step && goto_en) |=> fetch_addr == $past(goto_target));

  a_r4_goto_keeps_page: assert property (@(posedge clk) disable iff (rst)
    (step && goto_en && !lat_wr_en) |=> $stable(latch_rd));

  a_r6_write_uses_old_page: assert property (@(posedge clk) disable iff (rst)
    (step && !goto_en && pcl_wr_en)
      |=> fetch_addr == {$past(latch_rd[HI_W-1:0]), $past(pcl_data)});

  a_r7_add_no_carry: assert property (@(posedge clk) disable iff (rst)
    (step && !goto_en && !pcl_wr_en && pcl_add_en)
      |=> fetch_addr[ADDR_W-1:DATA_W] == $past(latch_rd[HI_W-1:0]));
endmodule

bind split_latch_pc pcs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .step        (step),
  .goto_en     (goto_en),
  .goto_target (goto_target),
  .pcl_wr_en   (pcl_wr_en),
  .pcl_add_en  (pcl_add_en),
  .pcl_data    (pcl_data),
  .lat_wr_en   (lat_wr_en),
  .fetch_addr  (fetch_addr),
  .latch_rd    (latch_rd)
);

// File: tb/sim_split_latch_pc.sv
module sim_split_latch_pc;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic        st;
    logic        gt;
    logic [10:0] tgt;
    logic        wr;
    logic        ad;
    logic [7:0]  pd;
    logic        lw;
    logic [7:0]  ld;
    logic [10:0] ef;
    logic [2:0]  el;
  } vec_t;

  localparam int NV = 15;
  // Walked from reset; expected fetch address and page after each edge
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 11'h000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 11'h001, 3'd0}, // R2
    '{1'b1, 1'b0, 11'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'h05, 11'h002, 3'd5}, // R5
    '{1'b1, 1'b0, 11'h000, 1'b0, 1'b0, 8'h00, 1'b1, 8'hFA, 11'h003, 3'd2}, // R5 upper dropped
    '{1'b1, 1'b0, 11'h000, 1'b1, 1'b0, 8'h40, 1'b0, 8'h00, 11'h240, 3'd2}, // R6
    '{1'b1, 1'b0, 11'h000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 11'h241, 3'd2}, // R2
    '{1'b1, 1'b0, 11'h000, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 11'h242, 3'd2}, // R7 offset 0
    '{1'b1, 1'b0, 11'h000, 1'b0, 1'b1, 8'hC0, 1'b0, 8'h00, 11'h203, 3'd2}, // R7 no carry
    '{1'b0, 1'b1, 11'h123, 1'b1, 1'b1, 8'h77, 1'b1, 8'h07, 11'h203, 3'd2}, // R3 stall
    '{1'b1, 1'b1, 11'h7FE, 1'b1, 1'b0, 8'h11, 1'b0, 8'h00, 11'h7FE, 3'd2}, // R4 R9
    '{1'b1, 1'b0, 11'h000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 11'h7FF, 3'd2}, // R2
    '{1'b1, 1'b0, 11'h000, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 11'h000, 3'd2}, // R2 wrap
    '{1'b1, 1'b0, 11'h000, 1'b1, 1'b0, 8'h10, 1'b1, 8'h06, 11'h210, 3'd6}, // R6 old page
    '{1'b1, 1'b0, 11'h000, 1'b1, 1'b1, 8'h20, 1'b0, 8'h00, 11'h620, 3'd6}, // R9 write over add
    '{1'b1, 1'b0, 11'h000, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h00, 11'h620, 3'd6}, // R7 wrap in byte
    '{1'b1, 1'b1, 11'h155, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 11'h155, 3'd6}  // R4 page kept
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        step, goto_en, pcl_wr_en, pcl_add_en, lat_wr_en;
  logic [10:0] goto_target;
  logic [7:0]  pcl_data, lat_data;
  logic [10:0] fetch_addr;
  logic [7:0]  pcl_rd, latch_rd;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  split_latch_pc u0 (
    .clk(clk), .rst(rst), .step(step), .goto_en(goto_en), .goto_target(goto_target),
    .pcl_wr_en(pcl_wr_en), .pcl_add_en(pcl_add_en), .pcl_data(pcl_data),
    .lat_wr_en(lat_wr_en), .lat_data(lat_data),
    .fetch_addr(fetch_addr), .pcl_rd(pcl_rd), .latch_rd(latch_rd)
  );

  task automatic drive(input vec_t v);
    step = v.st; goto_en = v.gt; goto_target = v.tgt; pcl_wr_en = v.wr;
    pcl_add_en = v.ad; pcl_data = v.pd; lat_wr_en = v.lw; lat_data = v.ld;
  endtask

  task automatic idle();
    step = 0; goto_en = 0; goto_target = '0; pcl_wr_en = 0;
    pcl_add_en = 0; pcl_data = '0; lat_wr_en = 0; lat_data = '0;
  endtask

  // One edge later, sampled a quarter period after the edge
  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic check_state(input string req, input logic [10:0] ef, input logic [2:0] el);
    logic [10:0] nx;
    nx = ef + 11'd1;
    checks++;
    if (fetch_addr !== ef || latch_rd !== {5'b0, el} || pcl_rd !== nx[7:0]) begin
      errors++;
      $display("FAIL %s fetch=%h/%h latch=%h/%h pcl_rd=%h/%h (actual/expected)",
               req, fetch_addr, ef, latch_rd, {5'b0, el}, pcl_rd, nx[7:0]);
    end
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_state("R1 reset state", 11'h000, 3'd0);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      tick();
      check_state($sformatf("vector %0d (R8 reads)", i), VEC[i].ef, VEC[i].el);
    end

    // R1: reset mid-run wins over a retiring jump and a page write
    @(negedge clk);
    drive('{1'b1, 1'b1, 11'h3AA, 1'b0, 1'b0, 8'h00, 1'b1, 8'h03, 11'h000, 3'd0});
    rst = 1'b1;
    tick();
    check_state("R1 reset mid-run", 11'h000, 3'd0);
    @(negedge clk);
    rst = 1'b0;
    idle();

    // R2: wrap from the last word via a jump there
    @(negedge clk);
    drive('{1'b1, 1'b1, 11'h7FF, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 11'h7FF, 3'd0});
    tick();
    check_state("R4 goto last word", 11'h7FF, 3'd0);
    @(negedge clk);
    idle();
    step = 1'b1;
    tick();
    check_state("R2 wrap to zero", 11'h000, 3'd0);

    // R3: a long stall with a page write pending stays put
    @(negedge clk);
    idle();
    lat_wr_en = 1'b1; lat_data = 8'h04; pcl_wr_en = 1'b1; pcl_data = 8'h99;
    repeat (3) tick();
    check_state("R3 stall ignores controls", 11'h000, 3'd0);

    // R7: add from a page boundary, offset wraps within the byte
    @(negedge clk);
    idle();
    step = 1'b1; lat_wr_en = 1'b1; lat_data = 8'h01;
    tick();
    check_state("R5 page write", 11'h001, 3'd1);
    @(negedge clk);
    idle();
    step = 1'b1; pcl_add_en = 1'b1; pcl_data = 8'hFE;
    tick();
    check_state("R7 add 0x02+0xFE stays in page", 11'h100, 3'd1);

    @(negedge clk);
    idle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule